// File: doc/BRIEF.md
# Debug Exception Redirection Unit

This unit sits next to a small processor's exception logic. It gathers the five events that lead to vector 1: the one-byte breakpoint opcode, a software vector-1 interrupt, a trap-flag single step, a breakpoint exception, and a task switch into a task whose trap bit is set. For each event it decides whether to issue a normal vector-1 dispatch or an emulator-break request. The opcode compare is made here on the byte the decoder presents. The unit also produces the trap-flag value to place in the saved flags image. Its companion logic performs the stack push and runs the handlers.

A single redirection bit picks the destination. When the bit is clear, every event becomes a vector-1 dispatch. When it is set, every event becomes an emulator break. If no emulator is attached at that point, the unit raises a sticky hang output and issues nothing more until reset. A configuration input decides which interface owns the bit: the software debug-control write port or the external debug port. Writes from the other interface are ignored. The bit may change at any time, including while a request is outstanding.

The controller has four states. IDLE waits for events. VEC_PEND holds a vector-1 dispatch. EMU_PEND holds an emulator break. HUNG is terminal. The transitions are:
- IDLE_TO_VEC: an event arrives and redirection is off.
- IDLE_TO_EMU: an event arrives, redirection is on and an emulator is attached.
- IDLE_TO_HUNG: an event arrives, redirection is on and no emulator is attached.
- PEND_TO_IDLE: an acknowledge arrives while VEC_PEND or EMU_PEND is held.
- HUNG_STAY: HUNG is never left until reset.

Top module: `dbg_redirect_unit`

## Requirements
- R1: After reset there is no request, hang is low, req_cause is 0 and push_tf is 0. Redirection is off, so the first event produces a vector-1 dispatch.
- R2: op_valid together with op_byte equal to 8'hF1 counts as the opcode event. Any other byte value raises nothing.
- R3: With redirection off, an event accepted in IDLE asserts vec1_req from the next clock edge onward.
- R4: push_tf equals saved_tf sampled in the acceptance cycle for every cause except single step (cause 3), which pushes 1. For the opcode event this means the trap flag is never set or altered.
- R5: With redirection on and emu_attached high, each of the five events asserts emu_brk_req and never vec1_req.
- R6: With redirection on and emu_attached low, an accepted event sets hang from the next edge onward. hang stays high until reset, and no request is issued while it is high.
- R7: When cfg_xport_sel is 0, only dcr_we/dcr_redir write the bit. When it is 1, only xp_we/xp_redir write it. A write takes effect one cycle later and is allowed while a request is pending.
- R8: Simultaneous events yield one request. The winner is chosen in this order, highest first, and reported on req_cause as: task-switch trap 1, breakpoint 2, single step 3, software vector 1 4, opcode 5.
- R9: A request, together with its req_cause and push_tf, holds until a cycle with req_ack high. It is low on the following cycle. Events arriving while a request is pending, including in the acknowledge cycle, are dropped.
- R10: vec1_req, emu_brk_req and hang are never high together. req_cause is 0 whenever no request is out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Decoder presents an opcode byte this cycle |
| op_byte | input | 8 | First opcode byte |
| ev_swint1 | input | 1 | Software vector-1 interrupt pulse |
| ev_step | input | 1 | Trap-flag single-step completion pulse |
| ev_brkpt | input | 1 | Breakpoint exception pulse |
| ev_task_trap | input | 1 | Task switch into a task with its trap bit set |
| saved_tf | input | 1 | Trap flag of the flags image being saved |
| cfg_xport_sel | input | 1 | 1: external port owns the redirection bit |
| dcr_we | input | 1 | Software debug-control write strobe |
| dcr_redir | input | 1 | Software value for the redirection bit |
| xp_we | input | 1 | External debug-port write strobe |
| xp_redir | input | 1 | External-port value for the redirection bit |
| emu_attached | input | 1 | An emulator is connected |
| req_ack | input | 1 | One-cycle acknowledge of the pending request |
| vec1_req | output | 1 | Normal vector-1 dispatch request |
| emu_brk_req | output | 1 | Emulator-break request |
| req_cause | output | 3 | Cause code of the pending request |
| push_tf | output | 1 | Trap-flag value to push |
| hang | output | 1 | Sticky hang indication |

## Verification
The checker tests several properties on every cycle. The three outputs vec1_req, emu_brk_req and hang are mutually exclusive. hang is sticky. A request and its cause and trap value stay stable until acknowledged and drop right after. A single step always pushes a set trap flag. The bench's scenarios are needed for the rest: the priority choice among every combination of events, the routing under each redirection setting, the full opcode byte sweep, ownership of the bit by either write path, and the dropping of events that arrive while a request is held.

// File: rtl/dbg_redir_pkg.sv
package dbg_redir_pkg;
    localparam int EV_N    = 5;
    localparam int CAUSE_W = 3;

    // Event index order is also priority order (index 0 highest)
    localparam int EV_TASK  = 0;
    localparam int EV_BRK   = 1;
    localparam int EV_STEP  = 2;
    localparam int EV_SWINT = 3;
    localparam int EV_OPC   = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_STEP = 3'(EV_STEP + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VEC_PEND,
        ST_EMU_PEND,
        ST_HUNG
    } redir_state_e;
endpackage

// File: rtl/dbg_redir_opmatch.sv
module dbg_redir_opmatch #(
    parameter int              OP_W = 8,
    parameter logic [OP_W-1:0] CODE = 8'hF1
) (
    input  logic            valid,
    input  logic [OP_W-1:0] op,
    output logic            hit
);
    assign hit = valid && (op == CODE);
endmodule

// File: rtl/dbg_redir_enable.sv
module dbg_redir_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic use_xport,
    input  logic sw_we,
    input  logic sw_d,
    input  logic xp_we,
    input  logic xp_d,
    output logic redir
);
    logic wr_en;
    logic wr_d;

    always_comb begin
        wr_en = use_xport ? xp_we : sw_we;
        wr_d  = use_xport ? xp_d  : sw_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     redir <= 1'b0;
        else if (wr_en) redir <= wr_d;
    end
endmodule

// File: rtl/dbg_redir_arb.sv
module dbg_redir_arb
    import dbg_redir_pkg::*;
(
    input  logic [EV_N-1:0]    ev,
    output logic               any,
    output logic [CAUSE_W-1:0] cause
);
    always_comb begin
        cause = CAUSE_NONE;
        for (int i = EV_N - 1; i >= 0; i--) begin
            if (ev[i]) cause = CAUSE_W'(i + 1);
        end
        any = |ev;
    end
endmodule

// File: rtl/dbg_redir_fsm.sv
module dbg_redir_fsm
    import dbg_redir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               redir,
    input  logic               emu_attached,
    input  logic               ack,
    input  logic               saved_tf,
    output logic               vec1_req,
    output logic               emu_brk_req,
    output logic [CAUSE_W-1:0] req_cause,
    output logic               push_tf,
    output logic               hang
);
    redir_state_e       state, state_nx;
    logic [CAUSE_W-1:0] cause_q;
    logic               tf_q;
    logic               accept;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (any) begin
                    if (!redir)            state_nx = ST_VEC_PEND;  // IDLE_TO_VEC
                    else if (emu_attached) state_nx = ST_EMU_PEND;  // IDLE_TO_EMU
                    else                   state_nx = ST_HUNG;      // IDLE_TO_HUNG
                end
            end
            ST_VEC_PEND, ST_EMU_PEND: begin
                if (ack) state_nx = ST_IDLE;                        // PEND_TO_IDLE
            end
            ST_HUNG: state_nx = ST_HUNG;                            // HUNG_STAY
            default: state_nx = ST_IDLE;
        endcase
    end

    assign accept = (state == ST_IDLE) && any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            tf_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cause_q <= cause;
                tf_q    <= (cause == CAUSE_STEP) ? 1'b1 : saved_tf;
            end
        end
    end

    always_comb begin
        vec1_req    = 1'b0;
        emu_brk_req = 1'b0;
        hang        = 1'b0;
        req_cause   = CAUSE_NONE;
        push_tf     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_VEC_PEND: begin
                vec1_req  = 1'b1;
                req_cause = cause_q;
                push_tf   = tf_q;
            end
            ST_EMU_PEND: begin
                emu_brk_req = 1'b1;
                req_cause   = cause_q;
                push_tf     = tf_q;
            end
            ST_HUNG: hang = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dbg_redirect_unit.sv
module dbg_redirect_unit
    import dbg_redir_pkg::*;
#(
    parameter int              OP_W    = 8,
    parameter logic [OP_W-1:0] BRK_OPC = 8'hF1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [OP_W-1:0]    op_byte,
    input  logic               ev_swint1,
    input  logic               ev_step,
    input  logic               ev_brkpt,
    input  logic               ev_task_trap,
    input  logic               saved_tf,
    input  logic               cfg_xport_sel,
    input  logic               dcr_we,
    input  logic               dcr_redir,
    input  logic               xp_we,
    input  logic               xp_redir,
    input  logic               emu_attached,
    input  logic               req_ack,
    output logic               vec1_req,
    output logic               emu_brk_req,
    output logic [CAUSE_W-1:0] req_cause,
    output logic               push_tf,
    output logic               hang
);
    logic               opc_hit;
    logic               redir;
    logic [EV_N-1:0]    ev;
    logic               ev_any;
    logic [CAUSE_W-1:0] ev_cause;

    dbg_redir_opmatch #(.OP_W(OP_W), .CODE(BRK_OPC)) u_match (
        .valid(op_valid), .op(op_byte), .hit(opc_hit)
    );

    dbg_redir_enable u_enable (
        .clk(clk), .rst_n(rst_n), .use_xport(cfg_xport_sel),
        .sw_we(dcr_we), .sw_d(dcr_redir),
        .xp_we(xp_we), .xp_d(xp_redir), .redir(redir)
    );

    always_comb begin
        ev            = '0;
        ev[EV_TASK]   = ev_task_trap;
        ev[EV_BRK]    = ev_brkpt;
        ev[EV_STEP]   = ev_step;
        ev[EV_SWINT]  = ev_swint1;
        ev[EV_OPC]    = opc_hit;
    end

    dbg_redir_arb u_arb (.ev(ev), .any(ev_any), .cause(ev_cause));

    dbg_redir_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any(ev_any), .cause(ev_cause),
        .redir(redir), .emu_attached(emu_attached), .ack(req_ack),
        .saved_tf(saved_tf), .vec1_req(vec1_req), .emu_brk_req(emu_brk_req),
        .req_cause(req_cause), .push_tf(push_tf), .hang(hang)
    );
endmodule

// File: rtl/dbg_redirect_unit_chk.sv
module dbg_redirect_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ack,
    input logic       vec1_req,
    input logic       emu_brk_req,
    input logic [2:0] req_cause,
    input logic       push_tf,
    input logic       hang
);
    logic req_out;
    assign req_out = vec1_req || emu_brk_req;

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec1_req, emu_brk_req, hang}));

    p_idle_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_out |-> (req_cause == 3'd0));

    p_hang_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hang |=> hang);

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec1_req && !req_ack) |=> (vec1_req && $stable(req_cause) && $stable(push_tf)));

    p_emu_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_brk_req && !req_ack) |=> (emu_brk_req && $stable(req_cause) && $stable(push_tf)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out && req_ack) |=> !req_out);

    p_cause_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> (req_cause >= 3'd1 && req_cause <= 3'd5));

    p_step_tf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out && req_cause == 3'd3) |-> push_tf);
endmodule

bind dbg_redirect_unit dbg_redirect_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ack(req_ack),
    .vec1_req(vec1_req), .emu_brk_req(emu_brk_req),
    .req_cause(req_cause), .push_tf(push_tf), .hang(hang)
);

// File: tb/dbg_redirect_unit_test.sv
module dbg_redirect_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic       ev_swint1 = 1'b0, ev_step = 1'b0, ev_brkpt = 1'b0, ev_task_trap = 1'b0;
    logic       saved_tf = 1'b0;
    logic       cfg_xport_sel = 1'b0;
    logic       dcr_we = 1'b0, dcr_redir = 1'b0, xp_we = 1'b0, xp_redir = 1'b0;
    logic       emu_attached = 1'b0;
    logic       req_ack = 1'b0;
    logic       vec1_req, emu_brk_req, push_tf, hang;
    logic [2:0] req_cause;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dbg_redirect_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .ev_swint1(ev_swint1), .ev_step(ev_step), .ev_brkpt(ev_brkpt),
        .ev_task_trap(ev_task_trap), .saved_tf(saved_tf),
        .cfg_xport_sel(cfg_xport_sel), .dcr_we(dcr_we), .dcr_redir(dcr_redir),
        .xp_we(xp_we), .xp_redir(xp_redir), .emu_attached(emu_attached),
        .req_ack(req_ack), .vec1_req(vec1_req), .emu_brk_req(emu_brk_req),
        .req_cause(req_cause), .push_tf(push_tf), .hang(hang)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare all outputs: {vec1, emu, hang, cause, tf}
    task automatic chk_out(input string tag, input int v, input int e,
                           input int h, input int c, input int t);
        chk({tag, " vec1_req"}, int'(vec1_req), v);
        chk({tag, " emu_brk_req"}, int'(emu_brk_req), e);
        chk({tag, " hang"}, int'(hang), h);
        chk({tag, " req_cause"}, int'(req_cause), c);
        chk({tag, " push_tf"}, int'(push_tf), t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive events for one cycle at a falling edge; return at next falling edge
    // mask bit0 task, bit1 brkpt, bit2 step, bit3 swint, bit4 opcode
    task automatic pulse_ev(input int mask, input logic tf);
        ev_task_trap = mask[0];
        ev_brkpt     = mask[1];
        ev_step      = mask[2];
        ev_swint1    = mask[3];
        op_valid     = mask[4];
        op_byte      = 8'hF1;
        saved_tf     = tf;
        @(negedge clk);
        ev_task_trap = 1'b0; ev_brkpt = 1'b0; ev_step = 1'b0;
        ev_swint1 = 1'b0; op_valid = 1'b0; saved_tf = 1'b0;
    endtask

    task automatic ack();
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic sw_write(input logic d);
        dcr_we = 1'b1; dcr_redir = d;
        @(negedge clk);
        dcr_we = 1'b0; dcr_redir = 1'b0;
    endtask

    task automatic xp_write(input logic d);
        xp_we = 1'b1; xp_redir = d;
        @(negedge clk);
        xp_we = 1'b0; xp_redir = 1'b0;
    endtask

    function automatic int exp_cause(input int mask);
        for (int i = 0; i < 5; i++) if (mask[i]) return i + 1;
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk_out("R1 reset", 0, 0, 0, 0, 0);
        pulse_ev(5'b10000, 1'b0);
        chk_out("R1 redir off after reset", 1, 0, 0, 5, 0);
        ack();
        chk_out("R9 release", 0, 0, 0, 0, 0);

        // Exhaustive sweep: mode 0 off, 1 on+attached, 2 on+detached
        for (int mode = 0; mode < 3; mode++) begin
            for (int mask = 1; mask < 32; mask++) begin
                for (int tf = 0; tf < 2; tf++) begin
                    int c, t;
                    do_reset();
                    emu_attached = (mode == 1);
                    cfg_xport_sel = 1'b0;
                    if (mode != 0) sw_write(1'b1);
                    pulse_ev(mask, logic'(tf));
                    c = exp_cause(mask);
                    t = (c == 3) ? 1 : tf;
                    if (mode == 0)      chk_out("R3 R8 R4 vector path", 1, 0, 0, c, t);
                    else if (mode == 1) chk_out("R5 R8 R4 emulator path", 0, 1, 0, c, t);
                    else begin
                        chk_out("R6 hang", 0, 0, 1, 0, 0);
                        pulse_ev(mask, logic'(tf));
                        chk_out("R6 hang sticky", 0, 0, 1, 0, 0);
                        emu_attached = 1'b1;
                        sw_write(1'b0);
                        pulse_ev(1, 1'b0);
                        chk_out("R6 no request while hung", 0, 0, 1, 0, 0);
                        emu_attached = 1'b0;
                    end
                    if (mode != 2) begin
                        // R9: a further event while pending is dropped
                        pulse_ev(5'b00001, 1'b1);
                        chk("R9 held cause", int'(req_cause), c);
                        chk("R9 held tf", int'(push_tf), t);
                        // event during ack cycle is dropped too
                        ev_swint1 = 1'b1;
                        ack();
                        ev_swint1 = 1'b0;
                        chk_out("R9 ack drops request", 0, 0, 0, 0, 0);
                        @(negedge clk);
                        chk_out("R9 event in ack cycle dropped", 0, 0, 0, 0, 0);
                    end
                end
            end
        end

        // R2: opcode byte sweep with redirection off
        do_reset();
        for (int b = 0; b < 256; b++) begin
            op_valid = 1'b1; op_byte = 8'(b); saved_tf = 1'b1;
            @(negedge clk);
            op_valid = 1'b0; saved_tf = 1'b0;
            chk("R2 opcode compare", int'(vec1_req), (b == 8'hF1) ? 1 : 0);
            if (vec1_req) begin
                chk("R2 R4 opcode keeps tf", int'(push_tf), 1);
                ack();
            end
        end
        op_byte = 8'hF1;
        @(negedge clk);
        chk("R2 no valid no event", int'(vec1_req), 0);

        // R7: write-path ownership
        do_reset();
        emu_attached = 1'b1;
        cfg_xport_sel = 1'b1;
        sw_write(1'b1);
        pulse_ev(5'b01000, 1'b0);
        chk_out("R7 sw write ignored with xport sel", 1, 0, 0, 4, 0);
        // change bit while the vector request is pending
        xp_write(1'b1);
        chk("R7 pending path unchanged", int'(vec1_req), 1);
        ack();
        pulse_ev(5'b01000, 1'b0);
        chk_out("R7 xport write takes effect", 0, 1, 0, 4, 0);
        ack();
        cfg_xport_sel = 1'b0;
        xp_write(1'b0);
        pulse_ev(5'b00010, 1'b1);
        chk_out("R7 xport write ignored with sw sel", 0, 1, 0, 2, 1);
        ack();
        sw_write(1'b0);
        pulse_ev(5'b00010, 1'b1);
        chk_out("R7 sw write clears bit", 1, 0, 0, 2, 1);
        ack();

        // R7: write and event in the same cycle use the old bit value
        dcr_we = 1'b1; dcr_redir = 1'b1;
        pulse_ev(5'b00100, 1'b0);
        dcr_we = 1'b0; dcr_redir = 1'b0;
        chk_out("R7 write visible next cycle", 1, 0, 0, 3, 1);
        ack();

        // R9: long hold without ack, R10 exclusivity
        pulse_ev(5'b10000, 1'b0);
        repeat (5) @(negedge clk);
        chk_out("R9 R10 long hold", 0, 1, 0, 5, 0);
        ack();
        chk_out("R9 released", 0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule